// File: doc/BRIEF.md
# Auto-Baud Divisor Range Filter

This block sits between a UART auto-baud detector and the baud-rate generator. Each time the detector finishes a measurement it raises a one-cycle done strobe together with a measured 16-bit divisor. The filter compares that divisor with an acceptance window. The window is centred on a programmed default divisor and extends by a programmed tolerance on each side. The filter then chooses the divisor the baud generator should run with.

A measurement inside the window is used directly. It is also folded into a 16-sample leaky integrator, whose quotient by 16 is the running average. A measurement outside the window is discarded: the generator is given the current running average instead, and an out-of-range flag is raised. For example, with a default of 0x0067 and a tolerance of 0x05 (about 5 percent), values from 0x0062 to 0x006C are accepted.

A small controller has four states:
- `ST_PRIME` is entered on reset. It loads the integrator with 15 times the default and the average with the default.
- `ST_READY` means defaults are loaded and no measurement has been seen.
- `ST_TAKEN` means the last measurement was accepted.
- `ST_REJECTED` means the last measurement was replaced.

Transitions:
- PRIME→READY is taken unconditionally on the first edge.
- From READY, TAKEN or REJECTED, a strobe with an in-window value goes to TAKEN.
- From those same states, a strobe with an out-of-window value goes to REJECTED.
- With no strobe, the state holds.

Top module: `autobaud_range_filter`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the selected divisor, the average and the out-of-range flag are all zero.
- R2: On the first clock edge after reset release, the selected divisor and the average become the default divisor, the flag stays 0, and the integrator becomes 15 times the default. A done strobe on that edge is ignored.
- R3: A measurement m is in the window exactly when default − tolerance ≤ m ≤ default + tolerance, both bounds inclusive. The bounds are computed without wraparound: a lower bound below 0 admits 0, and an upper bound above 0xFFFF admits 0xFFFF.
- R4: On the edge that samples a done strobe with an in-window measurement, the selected divisor becomes the measurement and the out-of-range flag becomes 0.
- R5: On that same accepting edge, with integrator I, the block forms S = I + m. The new average is floor(S/16), and the integrator becomes S − floor(S/16).
- R6: On the edge that samples a done strobe with an out-of-window measurement, the selected divisor becomes the average held before that edge and the flag becomes 1. The average and the integrator are unchanged.
- R7: With no done strobe, the selected divisor, the average and the flag hold their values; the flag therefore stays valid until the next strobe.
- R8: The integrator never overflows. With default 0xFFFF and repeated 0xFFFF measurements, the average stays at 0xFFFF.
- R9: Changing the default after the priming edge moves only the window. The integrator and the average keep evolving from their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_div | input | 16 | Divisor measured by the auto-baud detector |
| meas_done | input | 1 | One-cycle strobe: measurement complete |
| dflt_div | input | 16 | Programmed default divisor |
| tol_div | input | 16 | Programmed tolerance, in divisor counts |
| use_div | output | 16 | Divisor handed to the baud generator |
| avg_div | output | 16 | Current running average |
| out_of_range | output | 1 | Last measurement was outside the window |

## Verification
The assertions assume the default divisor is stable from reset release through the priming edge. The bench holds it fixed across every reset and changes it only later, to exercise R9. The no-overflow property relies on the invariant that the integrator starts at no more than 15 times the largest divisor. That invariant comes from the priming load, so any in-range measurement value is legal. The random stimulus draws measurements around the default that span twice the tolerance on each side. This lands values inside, on and just beyond both window edges. Directed cases add a clamped lower bound, an upper bound beyond 0xFFFF, and a default change after priming.

// File: rtl/abf_pkg.sv
package abf_pkg;

    typedef enum logic [1:0] {
        ST_PRIME    = 2'd0,
        ST_READY    = 2'd1,
        ST_TAKEN    = 2'd2,
        ST_REJECTED = 2'd3
    } abf_state_t;

endpackage

// File: rtl/abf_window.sv
module abf_window #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] meas,
    input  logic [DIV_W-1:0] dflt,
    input  logic [DIV_W-1:0] tol,
    output logic             in_win
);
    localparam int EXT_W = DIV_W + 1;

    logic [EXT_W-1:0] meas_x;
    logic [EXT_W-1:0] dflt_x;
    logic [EXT_W-1:0] tol_x;
    logic [EXT_W-1:0] upper;
    logic [EXT_W-1:0] meas_plus_tol;
    logic             above_low;
    logic             below_high;

    // One extra bit so neither bound wraps (R3)
    always_comb begin
        meas_x        = {1'b0, meas};
        dflt_x        = {1'b0, dflt};
        tol_x         = {1'b0, tol};
        upper         = dflt_x + tol_x;
        meas_plus_tol = meas_x + tol_x;
        above_low     = (meas_plus_tol >= dflt_x);
        below_high    = (meas_x <= upper);
        in_win        = above_low && below_high;
    end

endmodule

// File: rtl/abf_integrator.sv
module abf_integrator #(
    parameter int DIV_W = 16,
    parameter int SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             update,
    input  logic [DIV_W-1:0] dflt,
    input  logic [DIV_W-1:0] meas,
    output logic [DIV_W-1:0] avg_o
);
    localparam int INT_W = DIV_W + SHIFT + 1;
    localparam logic [INT_W-1:0] INT_MAX =
        INT_W'(((64'd1 << DIV_W) - 64'd1) * ((64'd1 << SHIFT) - 64'd1));

    logic [INT_W-1:0] integ_q;
    logic [DIV_W-1:0] avg_q;
    logic [INT_W-1:0] dflt_w;
    logic [INT_W-1:0] seed;
    logic [INT_W-1:0] sum;
    logic [DIV_W-1:0] new_avg;
    logic [INT_W-1:0] new_avg_w;

    always_comb begin
        dflt_w    = INT_W'(dflt);
        seed      = (dflt_w << SHIFT) - dflt_w;
        sum       = integ_q + INT_W'(meas);
        new_avg   = sum[SHIFT +: DIV_W];
        new_avg_w = INT_W'(new_avg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q <= '0;
            avg_q   <= '0;
        end else if (load) begin
            integ_q <= seed;
            avg_q   <= dflt;
        end else if (update) begin
            integ_q <= sum - new_avg_w;
            avg_q   <= new_avg;
        end
    end

    assign avg_o = avg_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        integ_q <= INT_MAX); // R8

    AST_HOLD_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !update) |=> $stable(integ_q)); // R6

endmodule

// File: rtl/abf_ctrl.sv
module abf_ctrl
    import abf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic in_win,
    output logic load,
    output logic accept,
    output logic reject,
    output logic oor
);
    abf_state_t state_q;
    abf_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_READY;
            ST_READY, ST_TAKEN, ST_REJECTED: begin
                if (strobe) state_d = in_win ? ST_TAKEN : ST_REJECTED;
            end
            default: state_d = ST_PRIME;
        endcase
    end

    always_comb begin
        load   = 1'b0;
        accept = 1'b0;
        reject = 1'b0;
        oor    = 1'b0;
        unique case (state_q)
            ST_PRIME: load = 1'b1;
            ST_READY, ST_TAKEN: begin
                accept = strobe && in_win;
                reject = strobe && !in_win;
            end
            ST_REJECTED: begin
                accept = strobe && in_win;
                reject = strobe && !in_win;
                oor    = 1'b1;
            end
            default: load = 1'b1;
        endcase
    end

    AST_PRIME_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> (state_q == ST_READY)); // R2

endmodule

// File: rtl/autobaud_range_filter.sv
module autobaud_range_filter #(
    parameter int DIV_W = 16,
    parameter int SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] meas_div,
    input  logic             meas_done,
    input  logic [DIV_W-1:0] dflt_div,
    input  logic [DIV_W-1:0] tol_div,
    output logic [DIV_W-1:0] use_div,
    output logic [DIV_W-1:0] avg_div,
    output logic             out_of_range
);
    logic             in_win;
    logic             ld;
    logic             acc;
    logic             rej;
    logic [DIV_W-1:0] sel_q;

    abf_window #(.DIV_W(DIV_W)) u_window (
        .meas   (meas_div),
        .dflt   (dflt_div),
        .tol    (tol_div),
        .in_win (in_win)
    );

    abf_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (meas_done),
        .in_win (in_win),
        .load   (ld),
        .accept (acc),
        .reject (rej),
        .oor    (out_of_range)
    );

    abf_integrator #(.DIV_W(DIV_W), .SHIFT(SHIFT)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ld),
        .update (acc),
        .dflt   (dflt_div),
        .meas   (meas_div),
        .avg_o  (avg_div)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sel_q <= '0;
        else if (ld)  sel_q <= dflt_div;
        else if (acc) sel_q <= meas_div;
        else if (rej) sel_q <= avg_div;
    end

    assign use_div = sel_q;

    AST_PRIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (use_div == $past(dflt_div)) && (avg_div == $past(dflt_div)) && !out_of_range); // R2

    AST_TAKE_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (use_div == $past(meas_div)) && !out_of_range); // R4

    AST_REJECT_AVG: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> (use_div == $past(avg_div)) && $stable(avg_div) && out_of_range); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !meas_done) |=> $stable(use_div) && $stable(avg_div) && $stable(out_of_range)); // R7

endmodule

// File: tb/test_autobaud_range_filter.sv
module test_autobaud_range_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] meas_div = '0;
    logic        meas_done = 1'b0;
    logic [15:0] dflt_div = 16'h0067;
    logic [15:0] tol_div = 16'h0005;
    logic [15:0] use_div;
    logic [15:0] avg_div;
    logic        out_of_range;

    int tests = 0;
    int fails = 0;

    int m_int;
    int m_avg;
    int m_sel;
    int m_oor;

    always #5 clk = ~clk;

    autobaud_range_filter i_autobaud_range_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_div     (meas_div),
        .meas_done    (meas_done),
        .dflt_div     (dflt_div),
        .tol_div      (tol_div),
        .use_div      (use_div),
        .avg_div      (avg_div),
        .out_of_range (out_of_range)
    );

    function automatic bit win_ok(int m, int d, int t);
        return (m + t >= d) && (m <= d + t);
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " use_div"}, int'(use_div), m_sel);
        chk({req, " avg_div"}, int'(avg_div), m_avg);
        chk({req, " out_of_range"}, int'(out_of_range), m_oor);
    endtask

    // R1 / R2: reset, then priming edge with an ignored strobe
    task automatic do_reset(int d, int t);
        @(negedge clk);
        rst_n = 1'b0;
        meas_done = 1'b0;
        dflt_div = 16'(d);
        tol_div = 16'(t);
        repeat (2) @(negedge clk);
        m_sel = 0; m_avg = 0; m_oor = 0;
        chk_all("R1");
        rst_n = 1'b1;
        meas_div = 16'(d ^ 1);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
        m_int = 15 * d; m_avg = d; m_sel = d; m_oor = 0;
        chk_all("R2");
    endtask

    task automatic do_meas(int m, string req);
        int s;
        int na;
        meas_div = 16'(m);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
        if (win_ok(m, int'(dflt_div), int'(tol_div))) begin
            s = m_int + m;
            na = s >> 4;
            m_int = s - na;
            m_avg = na;
            m_sel = m;
            m_oor = 0;
        end else begin
            m_sel = m_avg;
            m_oor = 1;
        end
        chk_all(req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            meas_div = 16'($urandom);
            @(negedge clk);
        end
        chk_all("R7");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);

        // Example window 0x62..0x6C
        do_reset(16'h0067, 16'h0005);
        do_meas(16'h0062, "R3 low edge R4 R5");
        do_meas(16'h006C, "R3 high edge R4 R5");
        do_meas(16'h0061, "R3 below R6");
        idle(3);
        do_meas(16'h006D, "R3 above R6");
        do_meas(16'h0068, "R4 after reject");

        // R9: default moves after priming; stored state persists
        dflt_div = 16'h0200;
        tol_div = 16'h0010;
        do_meas(16'h0205, "R9 accept new window");
        do_meas(16'h0067, "R9 old value rejected");

        // R3: lower bound clamps at zero
        do_reset(16'h0003, 16'h000A);
        do_meas(16'h0000, "R3 clamp low");
        do_meas(16'h000E, "R3 beyond high");

        // R3: upper bound past 0xFFFF
        do_reset(16'hFFF0, 16'h0020);
        do_meas(16'hFFFF, "R3 clamp high");
        for (int i = 0; i < 40; i++) do_meas(16'hFFFF, "R8 drift to max");

        // R8: full-scale default and measurements
        do_reset(16'hFFFF, 16'h0000);
        for (int i = 0; i < 20; i++) do_meas(16'hFFFF, "R8 full scale");
        do_meas(16'hFFFE, "R3 zero tolerance");

        // Random configurations
        for (int c = 0; c < 4; c++) begin
            int d;
            int t;
            d = 16 + int'($urandom_range(0, 60000));
            t = int'($urandom_range(0, 300));
            do_reset(d, t);
            for (int k = 0; k < 150; k++) begin
                int off;
                int m;
                off = int'($urandom_range(0, 4 * t + 4)) - (2 * t + 2);
                m = d + off;
                if (m < 0) m = 0;
                if (m > 65535) m = 65535;
                do_meas(m, "R3 R4 R5 R6 random");
                if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule